// File: doc/BRIEF.md
# Multicycle Shared-Memory CPU Datapath

This block is the register-transfer datapath of a small 32-bit load/store processor. Each instruction runs as a series of clock steps. A single memory array serves both instruction fetch and data access. A single ALU performs every addition and comparison: the PC increment, the branch target, the data address and the R-type operations. Between steps, hidden registers hold the partial results. These are the instruction register, the memory data register, the two operand registers and the ALU result register. Each step therefore uses the value the previous step latched.

An external sequencer drives the block through individual steering and write-enable inputs. It receives back the opcode and function fields of the current instruction and a flag that is high whenever the live ALU result is zero. The supported operations are R-type add, sub, and, or and set-less-than, word load, word store and branch-if-equal. On reset, the internal memory is loaded with a fixed boot image. This image holds a short program and its data words.

Top module: `mc_datapath`

## Requirements
- R1: While rst_ni is low, the PC, the instruction register, the operand and result registers and every register-file entry are cleared, and the memory is loaded with the boot image. The boot image holds the program in words 0 to 12 and the data values 17 and 25 in words 16 and 17. After release, opcode_o and funct_o read 0 and the first fetch reads word 0.
- R2: Fetch addresses the memory with PC[..:2] when iord_i is 0. With ir_write_i high, the word is loaded into the instruction register. opcode_o is IR[31:26] and funct_o is IR[5:0].
- R3: When ir_write_i is low, the instruction register keeps its value.
- R4: At every clock edge, operand A captures the register addressed by IR[25:21] and operand B captures the one addressed by IR[20:16]. alu_src_b_i selects the second ALU operand: 0 gives B, 1 gives the constant 4, 2 gives sign-extended IR[15:0], and 3 gives that value shifted left by two. Backward branches (negative offsets) therefore resolve correctly.
- R5: alu_op_i selects the operation: 0 is add, 1 is subtract, and 2 decodes funct. The funct codes are 0x20 add, 0x22 sub, 0x24 and, 0x25 or, and 0x2a signed set-less-than, which gives 1 or 0. zero_o is high exactly when the live ALU result is 0.
- R6: The register write address is IR[15:11] when reg_dst_i is 1 and IR[20:16] when it is 0. The write data is the ALU result register when mem_to_reg_i is 0 and the memory data register when it is 1. The write happens at the clock edge when reg_write_i is high.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: When iord_i is 1, the memory address comes from the ALU result register. The memory data register captures the memory output at every edge.
- R9: With mem_write_i high, operand B is written to the addressed memory word at the clock edge.
- R10: The PC loads when pc_write_i is high, or when pc_write_cond_i is high and zero_o is high. Otherwise the PC holds its value.
- R11: The PC source is the live ALU result when pc_src_i is 0 and the ALU result register when it is 1. The first ALU operand is the PC when alu_src_a_i is 0 and A when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_write_i | input | 1 | Unconditional PC load |
| pc_write_cond_i | input | 1 | PC load when the ALU result is zero |
| iord_i | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_write_i | input | 1 | Memory write enable |
| ir_write_i | input | 1 | Instruction register load enable |
| reg_write_i | input | 1 | Register file write enable |
| reg_dst_i | input | 1 | Write address select: 0 rt, 1 rd |
| mem_to_reg_i | input | 1 | Write data select: 0 ALU result register, 1 memory data register |
| alu_src_a_i | input | 1 | First ALU operand: 0 PC, 1 A |
| alu_src_b_i | input | 2 | Second ALU operand select |
| alu_op_i | input | 2 | ALU operation class |
| pc_src_i | input | 1 | PC source: 0 live ALU, 1 ALU result register |
| opcode_o | output | 6 | IR[31:26] |
| funct_o | output | 6 | IR[5:0] |
| zero_o | output | 1 | Live ALU result is zero |

## Verification
The block exposes no register or memory contents at its ports. The hardest things to observe are whether a store really reached memory and whether register 0 really ignored a write. The bench acts as the sequencer and runs the boot program step by step. It loads back the stored word and compares it with its source register through the zero flag of a branch compare. To check register 0 after the program has tried to write it, the bench steers the PC to register 0 plus a load offset. It then fetches that address. The data value found there proves that register 0 was still zero.

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2b;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2a;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_FN  = 2'b10
  } alu_cls_e;

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [5:0] fn);
    return {OP_RTYPE, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                        logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // boot image: program in words 0..12, data in 16..17
  function automatic logic [31:0] boot_word(int idx);
    case (idx)
      0:  return enc_i(OP_LOAD,  5'd0, 5'd1, 16'd64);
      1:  return enc_i(OP_LOAD,  5'd0, 5'd2, 16'd68);
      2:  return enc_r(5'd1, 5'd2, 5'd3, FN_ADD);
      3:  return enc_i(OP_STORE, 5'd0, 5'd3, 16'd72);
      4:  return enc_i(OP_LOAD,  5'd0, 5'd4, 16'd72);
      5:  return enc_i(OP_BEQ,   5'd3, 5'd4, 16'd1);
      6:  return enc_r(5'd1, 5'd2, 5'd5, FN_SUB);
      7:  return enc_i(OP_BEQ,   5'd1, 5'd2, 16'd3);
      8:  return enc_r(5'd1, 5'd2, 5'd0, FN_ADD);
      9:  return enc_r(5'd1, 5'd2, 5'd6, FN_AND);
      10: return enc_r(5'd1, 5'd2, 5'd7, FN_OR);
      11: return enc_r(5'd2, 5'd1, 5'd8, FN_SLT);
      12: return enc_i(OP_BEQ,   5'd0, 5'd0, 16'hfff3);
      16: return 32'd17;
      17: return 32'd25;
      default: return 32'd0;
    endcase
  endfunction
endpackage

// File: rtl/mcd_alu.sv
`timescale 1ns/1ps
module mcd_alu
  import mcd_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [1:0]      op_i,
  input  logic [5:0]      funct_i,
  output logic [XLEN-1:0] res_o,
  output logic            zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_FN: begin
        unique case (funct_i)
          FN_SUB:  res_o = a_i - b_i;
          FN_AND:  res_o = a_i & b_i;
          FN_OR:   res_o = a_i | b_i;
          FN_SLT:  res_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
          default: res_o = a_i + b_i;
        endcase
      end
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mcd_regfile.sv
`timescale 1ns/1ps
module mcd_regfile
  import mcd_pkg::*;
#(
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra1_i,
  input  logic [AW-1:0]   ra2_i,
  output logic [XLEN-1:0] rd1_o,
  output logic [XLEN-1:0] rd2_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];
endmodule

// File: rtl/mcd_mem.sv
`timescale 1ns/1ps
module mcd_mem
  import mcd_pkg::*;
#(
  parameter int WORDS = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IW-1:0]   idx_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= boot_word(i);
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
  import mcd_pkg::*;
#(
  parameter int MEM_WORDS = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pc_write_i,
  input  logic       pc_write_cond_i,
  input  logic       iord_i,
  input  logic       mem_write_i,
  input  logic       ir_write_i,
  input  logic       reg_write_i,
  input  logic       reg_dst_i,
  input  logic       mem_to_reg_i,
  input  logic       alu_src_a_i,
  input  logic [1:0] alu_src_b_i,
  input  logic [1:0] alu_op_i,
  input  logic       pc_src_i,
  output logic [5:0] opcode_o,
  output logic [5:0] funct_o,
  output logic       zero_o
);
  localparam int MIW = $clog2(MEM_WORDS);

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, mdr_q, alu_out_q;
  logic [XLEN-1:0] mem_rdata, rf_rd1, rf_rd2, rf_wd;
  logic [XLEN-1:0] op_a, op_b, alu_res, imm_sx, pc_next;
  logic [MIW-1:0]  mem_idx;
  logic [RAW-1:0]  rf_wa;
  logic            alu_zero, pc_load;

  assign mem_idx = iord_i ? alu_out_q[MIW+1:2] : pc_q[MIW+1:2];

  mcd_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (mem_idx),
    .we_i    (mem_write_i),
    .wdata_i (b_q),
    .rdata_o (mem_rdata)
  );

  assign rf_wa = reg_dst_i    ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = mem_to_reg_i ? mdr_q       : alu_out_q;

  mcd_regfile #(.NREG(1 << RAW)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (ir_q[25:21]),
    .ra2_i  (ir_q[20:16]),
    .rd1_o  (rf_rd1),
    .rd2_o  (rf_rd2),
    .we_i   (reg_write_i),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd)
  );

  assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign op_a   = alu_src_a_i ? a_q : pc_q;

  always_comb begin
    unique case (alu_src_b_i)
      2'd0:    op_b = b_q;
      2'd1:    op_b = XLEN'(4);
      2'd2:    op_b = imm_sx;
      default: op_b = imm_sx << 2;
    endcase
  end

  mcd_alu u_alu (
    .a_i     (op_a),
    .b_i     (op_b),
    .op_i    (alu_op_i),
    .funct_i (ir_q[5:0]),
    .res_o   (alu_res),
    .zero_o  (alu_zero)
  );

  assign pc_next = pc_src_i ? alu_out_q : alu_res;
  assign pc_load = pc_write_i | (pc_write_cond_i & alu_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      ir_q      <= '0;
      a_q       <= '0;
      b_q       <= '0;
      mdr_q     <= '0;
      alu_out_q <= '0;
    end else begin
      if (pc_load)    pc_q <= pc_next;
      if (ir_write_i) ir_q <= mem_rdata;
      // step registers latch every cycle
      a_q       <= rf_rd1;
      b_q       <= rf_rd2;
      mdr_q     <= mem_rdata;
      alu_out_q <= alu_res;
    end
  end

  assign opcode_o = ir_q[31:26];
  assign funct_o  = ir_q[5:0];
  assign zero_o   = alu_zero;
endmodule

// File: rtl/mc_datapath_chk.sv
`timescale 1ns/1ps
module mc_datapath_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic [31:0] ir_i,
  input logic [31:0] a_i,
  input logic [31:0] mdr_i,
  input logic [31:0] mem_rdata_i,
  input logic        ir_write_i,
  input logic        pc_write_i,
  input logic        pc_write_cond_i,
  input logic        pc_src_i,
  input logic        alu_src_a_i,
  input logic [1:0]  alu_src_b_i,
  input logic [1:0]  alu_op_i,
  input logic        iord_i,
  input logic        zero_i
);
  a_r1_pc_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> pc_i == 32'd0);

  a_r2_fetch_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_write_i && !pc_src_i && !alu_src_a_i && alu_src_b_i == 2'd1 && alu_op_i == 2'd0)
    |=> pc_i == $past(pc_i) + 32'd4);

  a_r3_ir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_write_i |=> $stable(ir_i));

  a_r7_r0_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_i[25:21] == 5'd0 |=> a_i == 32'd0);

  a_r8_mdr_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iord_i |=> mdr_i == $past(mem_rdata_i));

  a_r10_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pc_write_i || (pc_write_cond_i && zero_i)) |=> $stable(pc_i));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .pc_i            (pc_q),
  .ir_i            (ir_q),
  .a_i             (a_q),
  .mdr_i           (mdr_q),
  .mem_rdata_i     (mem_rdata),
  .ir_write_i      (ir_write_i),
  .pc_write_i      (pc_write_i),
  .pc_write_cond_i (pc_write_cond_i),
  .pc_src_i        (pc_src_i),
  .alu_src_a_i     (alu_src_a_i),
  .alu_src_b_i     (alu_src_b_i),
  .alu_op_i        (alu_op_i),
  .iord_i          (iord_i),
  .zero_i          (zero_o)
);

// File: tb/sim_mc_datapath.sv
`timescale 1ns/1ps
module sim_mc_datapath;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pc_write, pc_write_cond, iord, mem_write, ir_write, reg_write;
  logic reg_dst, mem_to_reg, alu_src_a, pc_src;
  logic [1:0] alu_src_b, alu_op;
  logic [5:0] opcode, funct;
  logic zero;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc_datapath u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .pc_write_i(pc_write), .pc_write_cond_i(pc_write_cond),
    .iord_i(iord), .mem_write_i(mem_write), .ir_write_i(ir_write),
    .reg_write_i(reg_write), .reg_dst_i(reg_dst), .mem_to_reg_i(mem_to_reg),
    .alu_src_a_i(alu_src_a), .alu_src_b_i(alu_src_b), .alu_op_i(alu_op),
    .pc_src_i(pc_src), .opcode_o(opcode), .funct_o(funct), .zero_o(zero)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_clear();
    pc_write = 0; pc_write_cond = 0; iord = 0; mem_write = 0; ir_write = 0;
    reg_write = 0; reg_dst = 0; mem_to_reg = 0; alu_src_a = 0; pc_src = 0;
    alu_src_b = 2'd0; alu_op = 2'd0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // sequencer steps
  task automatic s_fetch(logic [5:0] eop, logic [5:0] efn, string req);
    ctl_clear(); ir_write = 1; alu_src_b = 2'd1; pc_write = 1;
    tick();
    chk({req, " opcode"}, 32'(opcode), 32'(eop));
    chk({req, " funct"},  32'(funct),  32'(efn));
  endtask

  task automatic s_decode();
    ctl_clear(); alu_src_b = 2'd3; tick();
  endtask

  task automatic s_exec_r(logic ez, string req);
    ctl_clear(); alu_src_a = 1; alu_op = 2'd2;
    #1 chk({req, " zero"}, 32'(zero), 32'(ez));
    tick();
  endtask

  task automatic s_wb_r();
    ctl_clear(); reg_dst = 1; reg_write = 1; tick();
  endtask

  task automatic s_load();
    ctl_clear(); alu_src_a = 1; alu_src_b = 2'd2; tick();
    ctl_clear(); iord = 1; tick();
    ctl_clear(); mem_to_reg = 1; reg_write = 1; tick();
  endtask

  task automatic s_store();
    ctl_clear(); alu_src_a = 1; alu_src_b = 2'd2; tick();
    ctl_clear(); iord = 1; mem_write = 1; tick();
  endtask

  task automatic s_beq(logic ez, string req);
    ctl_clear(); alu_src_a = 1; alu_op = 2'd1; pc_src = 1; pc_write_cond = 1;
    #1 chk({req, " zero"}, 32'(zero), 32'(ez));
    tick();
  endtask

  task automatic do_reset();
    ctl_clear(); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // scenarios
  task automatic t_reset();
    do_reset();
    chk("R1 opcode after reset", 32'(opcode), 32'h0);
    chk("R1 funct after reset",  32'(funct),  32'h0);
    s_fetch(6'h23, 6'h00, "R1/R2 first fetch at PC 0");
  endtask

  task automatic t_loads();
    s_decode(); s_load();                         // r1 = 17
    s_fetch(6'h23, 6'h04, "R2 fetch PC+4");
    s_decode(); s_load();                         // r2 = 25
  endtask

  task automatic t_ir_hold();
    ctl_clear(); tick();
    chk("R3 opcode held", 32'(opcode), 32'h23);
    chk("R3 funct held",  32'(funct),  32'h04);
  endtask

  task automatic t_add();
    s_fetch(6'h00, 6'h20, "R10 PC held on idle cycle");
    s_decode();
    s_exec_r(1'b0, "R5 add 17+25");
    s_wb_r();                                     // r3 = 42 via rd
  endtask

  task automatic t_store_load();
    s_fetch(6'h2b, 6'h08, "R2 store fetch");
    s_decode(); s_store();                        // word 18 = r3
    s_fetch(6'h23, 6'h08, "R2 reload fetch");
    s_decode(); s_load();                         // r4 = word 18
  endtask

  task automatic t_beq_taken();
    s_fetch(6'h04, 6'h01, "R2 beq fetch");
    s_decode();
    s_beq(1'b1, "R6/R8/R9 stored and reloaded equal");
    s_fetch(6'h04, 6'h03, "R4/R10 taken branch target");
  endtask

  task automatic t_beq_not_taken();
    s_decode();
    s_beq(1'b0, "R5 r1 vs r2 differ");
    s_fetch(6'h00, 6'h20, "R10 not taken falls through");
  endtask

  task automatic t_r0_write();
    s_decode();
    s_exec_r(1'b0, "R5 add into r0");
    s_wb_r();                                     // discarded
  endtask

  task automatic t_logic();
    s_fetch(6'h00, 6'h24, "R2 and fetch");
    s_decode(); s_exec_r(1'b0, "R5 and 17&25"); s_wb_r();
    s_fetch(6'h00, 6'h25, "R2 or fetch");
    s_decode(); s_exec_r(1'b0, "R5 or 17|25"); s_wb_r();
    s_fetch(6'h00, 6'h2a, "R2 slt fetch");
    s_decode(); s_exec_r(1'b1, "R5 slt 25<17 is 0"); s_wb_r();
  endtask

  task automatic t_backward();
    s_fetch(6'h04, 6'h33, "R2 back beq fetch");
    s_decode();
    s_beq(1'b1, "R7 r0 equals r0");
    s_fetch(6'h23, 6'h00, "R4 negative offset to word 0");
  endtask

  task automatic t_r0_probe();
    s_decode();                                   // A = r0, imm = 64
    ctl_clear(); alu_src_a = 1; alu_src_b = 2'd2; pc_write = 1; tick();
    s_fetch(6'h00, 6'h11, "R7/R11 PC=r0+64 reads data 17");
  endtask

  task automatic t_reset_again();
    do_reset();
    chk("R1 opcode cleared again", 32'(opcode), 32'h0);
    s_fetch(6'h23, 6'h00, "R1 PC back at 0");
  endtask

  initial begin
    ctl_clear();
    t_reset();
    t_loads();
    t_ir_hold();
    t_add();
    t_store_load();
    t_beq_taken();
    t_beq_not_taken();
    t_r0_write();
    t_logic();
    t_backward();
    t_r0_probe();
    t_reset_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule